// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

This block drives and samples 32 general-purpose pins through a small 32-bit register bus. The pins are grouped into four banks of eight. Every bank has the same register set, repeated at a stride of 0x40 bytes. Each bank has the following controls:

- a direction register, where a 1 makes the pin an input;
- an output latch;
- a synchronized input readback;
- a latched interrupt status with write-one-to-clear;
- a view of the status with the mask applied;
- an interrupt mask, set through one write address and cleared through another;
- a per-pin choice between edge and level triggering.

All banks feed one interrupt line. That line is high while any pending status bit is unmasked.

Software reads the status and masked-status views to see what happened, and writes ones to the status address to acknowledge it. Reads are combinational: `bus_rdata` reflects `bus_addr` in the same cycle. Writes take effect at the rising clock edge where `bus_we` is high. Reset is asynchronous and active low. Its release is synchronized inside the block, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: Address bits 7:6 select the bank and bits 5:0 select the register within that bank. Pin n belongs to bank n/8 at bit n%8. Its `pin_out` and `pin_oe` bits sit at index n.
- R2: After reset, every register reads back as follows. Mask (offset 0x08) is 0xFF. Direction (0x10) is 0xFF. Output latch (0x14), status (0x04), masked status (0x00) and level select (0x20) are 0. `pin_oe`, `pin_out` and `irq` are all 0.
- R3: The direction register at offset 0x10 sets `pin_oe` to the inverse of each bit, so 1 means input. The output latch at 0x14 drives `pin_out`. Both registers read back what was written.
- R4: Offset 0x18 returns each pin's level after a two-flop synchronizer, visible two clock edges after the pin changes. Writes to 0x18 change no register.
- R5: A pin in edge mode sets its status bit on a rising edge of its synchronized input, three clock edges after the pin rises. The bit stays set after the pin falls. A pin held high does not set it again.
- R6: Offset 0x20 reads back the level-mode pins, and a write loads it. A pin in level mode keeps its status bit set for as long as its synchronized input is high. Writing 0 returns the pin to edge mode.
- R7: Writing a 1 bit to offset 0x04 clears that pin's status bit. A trigger in the same cycle as the clear takes priority, so the bit stays set.
- R8: Writing 1 bits to offset 0x08 sets the matching mask bits. Writing 1 bits to offset 0x0C clears them. Offset 0x08 reads the mask, and 0x0C reads as zero.
- R9: Offset 0x00 is read-only and returns status AND NOT mask.
- R10: `irq` is high exactly when some bank has a status bit whose mask bit is clear.
- R11: Only data bits 7:0 carry information. Bits 31:8 of a write are ignored and read back as zero. Offsets 0x1C, 0x24 to 0x3C, and any offset with address bits 1:0 non-zero read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: bank in bits 7:6, register in bits 5:0 |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data (bits 7:0 used) |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output latch contents |
| pin_oe | output | 32 | Output enable, 1 drives the pin |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following in each bank:

- the effect of mask set and mask clear writes;
- that a status clear holds unless a trigger arrives in the same cycle;
- that no status bit appears without a trigger;
- that writes to the input readback leave direction and output untouched.

Other behaviour appears only in the bench's scenarios:

- the bank and bit mapping of all 32 pins;
- the exact three-edge latency from pin to status;
- the contrast between edge and level mode when a pin is held high;
- the reset values;
- the zero reads from unmapped offsets.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_MSTAT = 6'h00;
  localparam logic [OFF_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MSET  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DIR   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_OUT   = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IN    = 6'h18;
  localparam logic [OFF_W-1:0] OFF_LVL   = 6'h20;

  typedef struct packed {
    logic stat_clr;
    logic mask_set;
    logic mask_clr;
    logic dir;
    logic out;
    logic lvl;
    logic in_ro;
  } bank_wr_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_no = stage2_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic [SEC_W-1:0] pin_lvl_i,
  input  logic [SEC_W-1:0] pin_rise_i,
  output logic [SEC_W-1:0] rdata_o,
  output logic [SEC_W-1:0] pin_out_o,
  output logic [SEC_W-1:0] pin_oe_o,
  output logic             irq_o
);
  bank_wr_t wr;
  logic [SEC_W-1:0] dir_q, dir_d;
  logic [SEC_W-1:0] out_q, out_d;
  logic [SEC_W-1:0] mask_q, mask_d;
  logic [SEC_W-1:0] stat_q, stat_d;
  logic [SEC_W-1:0] lvl_q, lvl_d;
  logic [SEC_W-1:0] set_vec, clr_vec;

  always_comb begin
    wr.stat_clr = we_i && (off_i == OFF_STAT);
    wr.mask_set = we_i && (off_i == OFF_MSET);
    wr.mask_clr = we_i && (off_i == OFF_MCLR);
    wr.dir      = we_i && (off_i == OFF_DIR);
    wr.out      = we_i && (off_i == OFF_OUT);
    wr.lvl      = we_i && (off_i == OFF_LVL);
    wr.in_ro    = we_i && (off_i == OFF_IN);
  end

  always_comb begin
    set_vec = (lvl_q & pin_lvl_i) | (~lvl_q & pin_rise_i);
    clr_vec = wr.stat_clr ? wdata_i : '0;
  end

  always_comb begin
    dir_d  = dir_q;
    out_d  = out_q;
    mask_d = mask_q;
    lvl_d  = lvl_q;
    if (wr.dir)      dir_d  = wdata_i;
    if (wr.out)      out_d  = wdata_i;
    if (wr.lvl)      lvl_d  = wdata_i;
    if (wr.mask_set) mask_d = mask_q | wdata_i;
    if (wr.mask_clr) mask_d = mask_q & ~wdata_i;
    stat_d = (stat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      out_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      lvl_q  <= '0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      lvl_q  <= lvl_d;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_MSTAT: rdata_o = stat_q & ~mask_q;
      OFF_STAT:  rdata_o = stat_q;
      OFF_MSET:  rdata_o = mask_q;
      OFF_DIR:   rdata_o = dir_q;
      OFF_OUT:   rdata_o = out_q;
      OFF_IN:    rdata_o = pin_lvl_i;
      OFF_LVL:   rdata_o = lvl_q;
      default:   rdata_o = '0;
    endcase
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = ~dir_q;
  assign irq_o     = |(stat_q & ~mask_q);

  // R8: every bit written to the set address is masked afterwards
  a_r8_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.mask_set && !wr.mask_clr) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R8: every bit written to the clear address is unmasked afterwards
  a_r8_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.mask_clr |=> ((mask_q & $past(wdata_i)) == '0));
  // R7: a cleared bit stays clear unless a trigger arrived in that cycle
  a_r7_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.stat_clr |=> ((stat_q & $past(wdata_i & ~set_vec)) == '0));
  // R5: no status bit rises without a trigger in the previous cycle
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(rst_ni) |=> ((stat_q & ~$past(stat_q) & ~$past(set_vec)) == '0));
  // R4: a write to the input readback touches neither direction nor output
  a_r4_input_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.in_ro |=> ($stable(dir_q) && $stable(out_q)));
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_SEC = 4,
  parameter int unsigned SEC_W   = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OFF_W+$clog2(NUM_SEC)-1:0] bus_addr,
  input  logic                      bus_we,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_SEC*SEC_W-1:0]  pin_in,
  output logic [NUM_SEC*SEC_W-1:0]  pin_out,
  output logic [NUM_SEC*SEC_W-1:0]  pin_oe,
  output logic                      irq
);
  localparam int unsigned NPINS = NUM_SEC * SEC_W;
  localparam int unsigned SEL_W = $clog2(NUM_SEC);

  logic               rst_int_n;
  logic [SEL_W-1:0]   sel;
  logic [OFF_W-1:0]   off;
  logic [NPINS-1:0]   pin_lvl, pin_rise;
  logic [SEC_W-1:0]   bank_rd [NUM_SEC];
  logic [NUM_SEC-1:0] bank_irq;
  logic               unused_wdata_hi;

  assign sel = bus_addr[OFF_W +: SEL_W];
  assign off = bus_addr[OFF_W-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:SEC_W];

  gpio_rst_sync u_rst_sync (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_int_n)
  );

  gpio_in_sync #(.W(NPINS)) u_in_sync (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .pin_i  (pin_in),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_bank
    logic bank_we;
    assign bank_we = bus_we && (sel == SEL_W'(s));

    gpio_bank #(.SEC_W(SEC_W)) u_bank (
      .clk_i      (clk),
      .rst_ni     (rst_int_n),
      .we_i       (bank_we),
      .off_i      (off),
      .wdata_i    (bus_wdata[SEC_W-1:0]),
      .pin_lvl_i  (pin_lvl[s*SEC_W +: SEC_W]),
      .pin_rise_i (pin_rise[s*SEC_W +: SEC_W]),
      .rdata_o    (bank_rd[s]),
      .pin_out_o  (pin_out[s*SEC_W +: SEC_W]),
      .pin_oe_o   (pin_oe[s*SEC_W +: SEC_W]),
      .irq_o      (bank_irq[s])
    );
  end

  assign bus_rdata = {{(DATA_W-SEC_W){1'b0}}, bank_rd[sel]};
  assign irq       = |bank_irq;

  // R2: while the synchronized reset is held, no interrupt is raised
  a_r2_reset_quiet: assert property (@(posedge clk) !rst_int_n |-> !irq);
endmodule

// File: tb/gpio_sect_ctrl_bench.sv
module gpio_sect_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_sect_ctrl u_gpio_sect_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_dir, exp_out, pat;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(4);

    // R2 reset values in every bank
    chk("R2 pin_oe", pin_oe, 32'h0);
    chk("R2 pin_out", pin_out, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'h0);
    for (int s = 0; s < 4; s++) begin
      logic [7:0] b;
      b = 8'(s * 64);
      rd(b + 8'h08, d); chk("R2 mask", d, 32'hFF);
      rd(b + 8'h10, d); chk("R2 dir", d, 32'hFF);
      rd(b + 8'h14, d); chk("R2 out", d, 32'h0);
      rd(b + 8'h04, d); chk("R2 status", d, 32'h0);
      rd(b + 8'h00, d); chk("R2 masked", d, 32'h0);
      rd(b + 8'h20, d); chk("R2 level", d, 32'h0);
    end

    // R1 R3 R11: direction and output per bank, upper write bits ignored
    exp_dir = '0; exp_out = '0;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] dv, ov;
      dv = 8'h5A ^ 8'(s * 8'h33);
      ov = 8'hC3 + 8'(s * 17);
      wr(8'(s * 64) + 8'h10, 32'hABCD_EF00 | 32'(dv));
      wr(8'(s * 64) + 8'h14, 32'h1234_5600 | 32'(ov));
      exp_dir[s*8 +: 8] = dv;
      exp_out[s*8 +: 8] = ov;
    end
    chk("R3 R1 pin_oe", pin_oe, ~exp_dir);
    chk("R3 R1 pin_out", pin_out, exp_out);
    for (int s = 0; s < 4; s++) begin
      rd(8'(s * 64) + 8'h10, d); chk("R3 R11 dir readback", d, 32'(exp_dir[s*8 +: 8]));
      rd(8'(s * 64) + 8'h14, d); chk("R3 R11 out readback", d, 32'(exp_out[s*8 +: 8]));
    end

    // R4: input readback after synchronizer, writes ignored
    pat = 32'h9C3A_E571;
    @(negedge clk); pin_in = pat;
    wait_edges(1);
    rd(8'h18, d); chk("R4 not yet synced", d, 32'h0);
    wait_edges(2);
    for (int s = 0; s < 4; s++) begin
      rd(8'(s * 64) + 8'h18, d); chk("R4 input", d, 32'(pat[s*8 +: 8]));
      wr(8'(s * 64) + 8'h18, 32'hFFFF_FFFF);
    end
    chk("R4 write ignored oe", pin_oe, ~exp_dir);
    chk("R4 write ignored out", pin_out, exp_out);
    rd(8'h58, d); chk("R4 input after write", d, 32'(pat[15:8]));

    // R11 R8: unmapped and write-only offsets read zero
    rd(8'h1C, d); chk("R11 off 1C", d, 32'h0);
    rd(8'h64, d); chk("R11 off 24", d, 32'h0);
    rd(8'hBC, d); chk("R11 off 3C", d, 32'h0);
    rd(8'hC9, d); chk("R11 misaligned", d, 32'h0);
    rd(8'h8C, d); chk("R8 clear addr reads zero", d, 32'h0);

    // clear edges caused by the input pattern
    @(negedge clk); pin_in = '0;
    wait_edges(4);
    for (int s = 0; s < 4; s++) wr(8'(s * 64) + 8'h04, 32'hFF);

    // R5 R7 R9: each pin in edge mode, fully masked
    for (int n = 0; n < 32; n++) begin
      logic [7:0] b;
      logic [31:0] bit_v;
      b = 8'((n / 8) * 64);
      bit_v = 32'(1) << (n % 8);
      @(negedge clk); pin_in = 32'(1) << n;
      wait_edges(2);
      rd(b + 8'h04, d); chk("R5 not before third edge", d, 32'h0);
      wait_edges(2);
      rd(b + 8'h04, d); chk("R5 edge status", d, bit_v);
      rd(b + 8'h00, d); chk("R9 masked hides", d, 32'h0);
      chk("R10 masked irq low", {31'b0, irq}, 32'h0);
      @(negedge clk); pin_in = '0;
      wait_edges(4);
      rd(b + 8'h04, d); chk("R5 latched after fall", d, bit_v);
      wr(b + 8'h04, bit_v);
      rd(b + 8'h04, d); chk("R7 cleared", d, 32'h0);
    end

    // R8 R9 R10: unmask one pin per bank
    for (int s = 0; s < 4; s++) begin
      logic [7:0] b;
      logic [31:0] bit_v;
      b = 8'(s * 64);
      bit_v = 32'(1) << (2 * s + 1);
      wr(b + 8'h0C, bit_v);
      rd(b + 8'h08, d); chk("R8 mask cleared", d, 32'hFF & ~bit_v);
      chk("R10 no pending", {31'b0, irq}, 32'h0);
      @(negedge clk); pin_in = 32'(1) << (s * 8 + 2 * s + 1);
      wait_edges(4);
      chk("R10 irq high", {31'b0, irq}, 32'h1);
      rd(b + 8'h00, d); chk("R9 masked shows", d, bit_v);
      wr(b + 8'h08, bit_v);
      chk("R10 irq masked again", {31'b0, irq}, 32'h0);
      rd(b + 8'h08, d); chk("R8 mask set", d, 32'hFF);
      rd(b + 8'h00, d); chk("R9 masked after set", d, 32'h0);
      rd(b + 8'h04, d); chk("R9 raw keeps", d, bit_v);
      @(negedge clk); pin_in = '0;
      wait_edges(4);
      wr(b + 8'h04, 32'hFF);
    end

    // R6 R7: level mode on pin 11 (bank 1, bit 3)
    wr(8'h60, 32'h08);
    rd(8'h60, d); chk("R6 level readback", d, 32'h08);
    @(negedge clk); pin_in = 32'h0000_0800;
    wait_edges(4);
    rd(8'h44, d); chk("R6 level status", d, 32'h08);
    wr(8'h44, 32'h08);
    rd(8'h44, d); chk("R7 R6 set wins while high", d, 32'h08);
    @(negedge clk); pin_in = '0;
    wait_edges(4);
    rd(8'h44, d); chk("R6 latched after low", d, 32'h08);
    wr(8'h44, 32'h08);
    rd(8'h44, d); chk("R6 clears when low", d, 32'h0);

    // R6 R5: back to edge mode, held-high pin does not re-set
    wr(8'h60, 32'h00);
    rd(8'h60, d); chk("R6 edge mode restored", d, 32'h0);
    @(negedge clk); pin_in = 32'h0000_0800;
    wait_edges(4);
    rd(8'h44, d); chk("R5 edge after restore", d, 32'h08);
    wr(8'h44, 32'h08);
    wait_edges(2);
    rd(8'h44, d); chk("R5 R6 held high stays clear", d, 32'h0);
    @(negedge clk); pin_in = '0;
    wait_edges(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule